// File: doc/BRIEF.md
# Memory Fill Engine

This block writes one repeating 64-bit pattern over a contiguous region of memory. Configuration is written through a small word-wide register port: a destination pointer, a length in bytes, the two 32-bit halves of the pattern, a mode selector and an activation word whose bit 0 launches the fill. Once launched, the engine copies its configuration into working registers and presents a sequence of 64-bit write requests on a ready/valid port, one per 8-byte word, until the whole region is covered.

The `busy` output shows whether a fill is in progress. A one-cycle `done` pulse marks completion. A launch that asks for a length outside the legal range is refused and raises `err`. A launch issued during a running fill, or while another mode is selected, is refused without any trace.

Top module: `mfill_engine`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `done` and `err` are all low.
- R2: The register port has these fields. Address 0 is the destination pointer; its bits [2:0] are dropped. Address 1 is the length in bytes. Address 2 is pattern bits [31:0]. Address 3 is pattern bits [63:32]. Address 4 holds the mode in bits [1:0], and the value 2'b10 selects fill. Address 5 is the activation word; writing it with bit 0 set requests a launch.
- R3: A launch request is accepted when the engine is idle, the mode is 2'b10 and the length lies between 128 and 16777216 inclusive. `busy` is high starting with the clock edge that takes the activation write.
- R4: An accepted fill issues ceil(length/8) writes. The first address is the destination pointer with bits [2:0] cleared, and each following address is 8 higher. Every write carries {pattern high, pattern low}.
- R5: A write transfers only on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R6: After the last write transfers, `done` is high for exactly one cycle and `busy` falls in that same cycle.
- R7: A launch with a length outside [128, 16777216] sets `err`, leaves the engine idle and issues no writes. The next accepted launch clears `err`.
- R8: A launch request while `busy` is high is ignored. Register writes made during a fill do not change the writes of that fill.
- R9: A launch request while the mode is not 2'b10 is ignored: `busy` and `err` keep their values and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted by memory side |
| wr_addr | output | 32 | Byte address of the write, 8-byte aligned |
| wr_data | output | 64 | Pattern word to write |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last launch had an illegal length |

## Verification
The assertions assume that `wr_ready` is a plain level from the memory side that may change on any cycle. They also assume that register writes arrive one per cycle, each lasting a single cycle. The stimulus changes `wr_ready` from a pseudo-random sequence shortly after each rising edge, so stalls of several cycles occur in the middle of fills. Register writes are driven on falling edges and last one cycle each. Mid-fill reconfiguration and repeated launches are issued only through that same register port.

// File: rtl/mfill_pkg.sv
package mfill_pkg;
  localparam logic [2:0] RA_DST  = 3'd0;
  localparam logic [2:0] RA_LEN  = 3'd1;
  localparam logic [2:0] RA_PATL = 3'd2;
  localparam logic [2:0] RA_PATH = 3'd3;
  localparam logic [2:0] RA_MODE = 3'd4;
  localparam logic [2:0] RA_ACT  = 3'd5;

  typedef enum logic [1:0] {
    MD_NONE = 2'b00,
    MD_COPY = 2'b01,
    MD_FILL = 2'b10,
    MD_SUM  = 2'b11
  } fill_mode_e;
endpackage

// File: rtl/mfill_regs.sv
module mfill_regs
  import mfill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-4:0] cfg_dst_word,
  output logic [LEN_W-1:0]  cfg_len,
  output logic [63:0]       cfg_pat,
  output logic              cfg_fill_mode,
  output logic              launch_req
);
  logic [ADDR_W-4:0] dst_q, dst_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [31:0]       patl_q, patl_d, path_q, path_d;
  fill_mode_e        mode_q, mode_d;

  always_comb begin
    dst_d  = dst_q;
    len_d  = len_q;
    patl_d = patl_q;
    path_d = path_q;
    mode_d = mode_q;
    if (reg_we) begin
      case (reg_addr)
        RA_DST:  dst_d  = reg_wdata[ADDR_W-1:3];
        RA_LEN:  len_d  = LEN_W'(reg_wdata);
        RA_PATL: patl_d = reg_wdata;
        RA_PATH: path_d = reg_wdata;
        RA_MODE: mode_d = fill_mode_e'(reg_wdata[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      len_q  <= '0;
      patl_q <= '0;
      path_q <= '0;
      mode_q <= MD_NONE;
    end else if (reg_we) begin
      dst_q  <= dst_d;
      len_q  <= len_d;
      patl_q <= patl_d;
      path_q <= path_d;
      mode_q <= mode_d;
    end
  end

  assign cfg_dst_word  = dst_q;
  assign cfg_len       = len_q;
  assign cfg_pat       = {path_q, patl_q};
  assign cfg_fill_mode = (mode_q == MD_FILL);
  assign launch_req    = reg_we && (reg_addr == RA_ACT) && reg_wdata[0];
endmodule

// File: rtl/mfill_ctrl.sv
module mfill_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MIN_BYTES = 128,
  parameter int MAX_BYTES = 16777216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_req,
  input  logic              cfg_fill_mode,
  input  logic [ADDR_W-4:0] cfg_dst_word,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [63:0]       cfg_pat,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = $clog2(MAX_BYTES / 8 + 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [ADDR_W-4:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [63:0]       pat_q, pat_d;
  logic              go, len_ok, xfer, last;
  logic [CNT_W-1:0]  words_needed;

  assign len_ok = (cfg_len >= LEN_W'(MIN_BYTES)) && (cfg_len <= LEN_W'(MAX_BYTES));
  assign go     = launch_req && cfg_fill_mode && !busy_q;
  assign xfer   = busy_q && wr_ready;
  assign last   = xfer && (cnt_q == CNT_W'(1));
  assign words_needed = cfg_len[CNT_W+2:3] + CNT_W'(|cfg_len[2:0]);

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    word_d = word_q;
    cnt_d  = cnt_q;
    pat_d  = pat_q;
    done_d = last;
    if (go) begin
      if (len_ok) begin
        busy_d = 1'b1;
        err_d  = 1'b0;
        word_d = cfg_dst_word;
        cnt_d  = words_needed;
        pat_d  = cfg_pat;
      end else begin
        err_d  = 1'b1;
      end
    end else if (xfer) begin
      word_d = word_q + 1'b1;
      cnt_d  = cnt_q - 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
      pat_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (go || xfer) begin
        word_q <= word_d;
        cnt_q  <= cnt_d;
      end
      if (go && len_ok) pat_q <= pat_d;
    end
  end

  assign wr_valid = busy_q;
  assign wr_addr  = {word_q, 3'b000};
  assign wr_data  = pat_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[2:0] == 3'b000));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $fell(busy)));
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R4
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !done_d) |=> (wr_addr == $past(wr_addr) + ADDR_W'(8)));
endmodule

// File: rtl/mfill_engine.sv
module mfill_engine #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MIN_BYTES = 128,
  parameter int MAX_BYTES = 16777216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-4:0] cfg_dst_word;
  logic [LEN_W-1:0]  cfg_len;
  logic [63:0]       cfg_pat;
  logic              cfg_fill_mode;
  logic              launch_req;

  mfill_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_dst_word(cfg_dst_word), .cfg_len(cfg_len),
    .cfg_pat(cfg_pat), .cfg_fill_mode(cfg_fill_mode), .launch_req(launch_req)
  );

  mfill_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES),
               .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req),
    .cfg_fill_mode(cfg_fill_mode), .cfg_dst_word(cfg_dst_word),
    .cfg_len(cfg_len), .cfg_pat(cfg_pat), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );
endmodule

// File: tb/test_mfill_engine.sv
`timescale 1ns/1ps
module test_mfill_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        wr_valid, busy, done, err;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int done_seen = 0;
  logic prev_done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_addr_q[$];
  logic [63:0] exp_data_q[$];

  always #4 clk = ~clk;

  mfill_engine i_mfill_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Ready changes shortly after each rising edge (pseudo-random stalls).
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = lfsr[0] | lfsr[3];
  end

  // Monitor: pops expected writes and checks done timing.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (exp_addr_q.size() == 0) begin
          check("R4 unexpected write", {32'h0, wr_addr}, 64'hFFFF_FFFF);
        end else begin
          check("R4 addr", {32'h0, wr_addr}, {32'h0, exp_addr_q.pop_front()});
          check("R4 data", wr_data, exp_data_q.pop_front());
        end
      end
      if (done) begin
        done_seen++;
        check("R6 queue empty at done", 64'(exp_addr_q.size()), 64'd0);
        check("R6 busy low at done", {63'h0, busy}, 64'd0);
      end
      if (done && prev_done) check("R6 done width", 64'd2, 64'd1);
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] dst, input logic [31:0] len,
                       input logic [31:0] lo, input logic [31:0] hi);
    wreg(3'd0, dst);
    wreg(3'd1, len);
    wreg(3'd2, lo);
    wreg(3'd3, hi);
    wreg(3'd4, 32'h2);
  endtask

  task automatic push_fill(input logic [31:0] dst, input logic [31:0] len,
                           input logic [31:0] lo, input logic [31:0] hi);
    int n = int'((len + 7) / 8);
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back({dst[31:3], 3'b000} + 32'(8 * i));
      exp_data_q.push_back({hi, lo});
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_fill(input string req, input logic [31:0] dst,
                          input logic [31:0] len, input logic [31:0] lo,
                          input logic [31:0] hi);
    int d0;
    setup(dst, len, lo, hi);
    push_fill(dst, len, lo, hi);
    d0 = done_seen;
    wreg(3'd5, 32'h1);
    check({req, " busy after launch (R3)"}, {63'h0, busy}, 64'd1);
    check({req, " err cleared (R7)"}, {63'h0, err}, 64'd0);
    wait_idle();
    check({req, " all writes seen (R4)"}, 64'(exp_addr_q.size()), 64'd0);
    check({req, " one done pulse (R6)"}, 64'(done_seen - d0), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {63'h0, busy}, 64'd0);
    check("R1 wr_valid", {63'h0, wr_valid}, 64'd0);
    check("R1 done", {63'h0, done}, 64'd0);
    check("R1 err", {63'h0, err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 minimum length
    run_fill("R3 min", 32'h0000_1000, 32'd128, 32'h1234_5678, 32'h9ABC_DEF0);
    // R4 non-multiple length rounds up, unaligned pointer low bits dropped
    run_fill("R4 round", 32'h0000_2005, 32'd130, 32'hDEAD_BEEF, 32'h0BAD_F00D);
    run_fill("R2 pattern", 32'hFFFF_F000, 32'd1000, 32'hFFFF_FFFF, 32'h0000_0000);

    // R7 too short
    setup(32'h100, 32'd127, 32'h1, 32'h2);
    wreg(3'd5, 32'h1);
    check("R7 short busy", {63'h0, busy}, 64'd0);
    check("R7 short err", {63'h0, err}, 64'd1);
    // R7 too long
    setup(32'h100, 32'd16777217, 32'h1, 32'h2);
    wreg(3'd5, 32'h1);
    check("R7 long busy", {63'h0, busy}, 64'd0);
    check("R7 long err", {63'h0, err}, 64'd1);
    repeat (4) @(negedge clk);
    check("R7 no writes", {63'h0, wr_valid}, 64'd0);

    // R9 wrong mode: err keeps value, stays idle
    setup(32'h300, 32'd256, 32'h5, 32'h6);
    wreg(3'd4, 32'h1);
    wreg(3'd5, 32'h1);
    check("R9 busy", {63'h0, busy}, 64'd0);
    check("R9 err kept", {63'h0, err}, 64'd1);
    repeat (4) @(negedge clk);
    check("R9 no writes", {63'h0, wr_valid}, 64'd0);

    // R7 next good launch clears err; R8 relaunch and reconfig during fill
    setup(32'h4000, 32'd256, 32'hAAAA_5555, 32'h1111_2222);
    push_fill(32'h4000, 32'd256, 32'hAAAA_5555, 32'h1111_2222);
    wreg(3'd5, 32'h1);
    check("R7 err cleared", {63'h0, err}, 64'd0);
    wreg(3'd2, 32'h7777_7777);
    wreg(3'd0, 32'h9000);
    wreg(3'd1, 32'd128);
    wreg(3'd5, 32'h1);
    check("R8 still busy", {63'h0, busy}, 64'd1);
    wait_idle();
    check("R8 fill unchanged", 64'(exp_addr_q.size()), 64'd0);

    // R5 long run with stalls
    run_fill("R5 stall", 32'h0010_0000, 32'd2048, 32'h0F0F_0F0F, 32'hF0F0_F0F0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule